// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that runs a small 64-bit load/store instruction subset. It decodes the instruction word held in the fetch/decode pipe register. It keeps its own shadow copies of the control fields for the three later pipe registers. From these it drives every steering and sequencing signal the datapath needs: a source select for each ALU operand, a write-through select for each decode-stage register read, the register-file write port control, a freeze of the PC and the fetch/decode register, a bubble into the decode/execute register, and a flush that cancels the two youngest instructions when a control transfer resolves.

The register file is written from the decode stage rather than from a separate write-back stage. A result that leaves the memory/write-back register is therefore handed straight to the operand read of the same cycle. Conditional moves only decide in execute whether they write. The controller records that decision, so a suppressed move is never used as a bypass source and the value from an older writer is steered to the ALU instead. The datapath reports one fact back: whether ALU operand A, after bypass, is zero. That bit decides both conditional branches and conditional moves.

Top module: `hazard_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three shadow stages are empty. Both operand selects read 0, and stall, idex_bubble, flush, id_thru_a, id_thru_b and rf_we are all low, whatever instruction sits in the fetch/decode register.
- R2: Field layout of the 32-bit instruction word:
  - The opcode is bits 31:26.
  - Source A is bits 25:21 and source B is bits 20:16.
  - The operate-format destination is bits 4:0, the literal flag is bit 12 and the function code is bits 11:5.
  - Opcode 0x10 and opcode 0x11 are operate instructions. Within 0x11, function 0x24 is the move-if-zero and function 0x26 is the move-if-nonzero.
  - Opcodes 0x29 (load), 0x2D (store), 0x39 (branch if zero), 0x3D (branch if nonzero), 0x30 and 0x34 (unconditional branches) and 0x1A (jump) are decoded as described in R6, R8 and R10.
  - Any other opcode neither reads nor writes a register.
- R3: Each ALU operand select uses the code 0 for the register file, 1 for the execute/memory result and 2 for the memory/write-back result. A matching writer in execute/memory wins over one in memory/write-back, and the register file is chosen only when neither matches.
- R4: id_thru_a or id_thru_b is high when the instruction in memory/write-back writes the register that the instruction in decode reads in the same cycle. rf_we and rf_waddr carry that write, three cycles after the writer left decode.
- R5: Register 31 is never a bypass source, never a write-through source, never a stall cause, and never written through rf_we.
- R6: Operand use is as follows:
  - Operate instructions read source A, and read source B only when bit 12 is clear. With bit 12 set, bits 20:13 form a literal.
  - Loads read only source B.
  - Stores read A and B.
  - Conditional branches read only A.
  - The jump reads only B.
  - The unconditional branches read nothing.
  - A field that is not read never produces a bypass, write-through or stall.
- R7: A load in execute whose destination is read by the instruction in decode raises stall and idex_bubble for exactly one cycle. The consumer then reaches execute with the load result selected from memory/write-back.
- R8: When a branch resolves taken in execute, flush and idex_bubble are high in that cycle. A branch is taken when it is an unconditional branch, a jump, a branch-if-zero with operand A zero, or a branch-if-nonzero with operand A nonzero. A branch that is not taken leaves the pipeline running. Unconditional branches and the jump write their link to bits 25:21; conditional branches write nothing.
- R9: The move-if-zero writes its destination only when operand A is zero, and the move-if-nonzero only when it is nonzero. A move that does not write is never a bypass or write-through source, so an older writer of the same register is selected instead.
- R10: Stores never act as a writer, even when bits 25:21 match a later source.
- R11: An instruction marked invalid in the fetch/decode register, or one cancelled by a flush, enters execute as a bubble. It never causes a stall or a bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ifid_valid | input | 1 | Fetch/decode register holds a live instruction |
| ifid_insn | input | 32 | Instruction word in the fetch/decode register |
| ex_opa_zero | input | 1 | Bypassed ALU operand A of the execute instruction is zero |
| fwd_a_sel | output | 2 | ALU operand A source (0 register file, 1 execute/memory, 2 memory/write-back) |
| fwd_b_sel | output | 2 | ALU operand B source, same encoding |
| id_thru_a | output | 1 | Decode read of source A takes the write-back data |
| id_thru_b | output | 1 | Decode read of source B takes the write-back data |
| rf_we | output | 1 | Register file write enable for the decode-stage write |
| rf_waddr | output | 5 | Register file write address |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| flush | output | 1 | Clear the fetch/decode register and load the PC with the branch target |

## Verification
A shadow stage that holds a wrong destination or write flag shows up within one to three cycles. It appears as a wrong operand select when the consumer reaches execute, or as a wrong write-through or rf_we while the consumer is in decode. The sweep therefore places one producer of every kind one, two and three instructions ahead of consumers with every operand-use pattern. It does this for an ordinary register and for register 31, and it checks the stall, the write-through and the execute-stage select at each step. A lost bubble after a flush or stall only appears two cycles later as a bypass from a stage that should be empty, so the branch checks follow the cancelled slot to that point.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
// Package hz_pkg
// Shared field positions, opcodes and control types for the hazard controller.
// Assumes a 32-bit instruction word with 32 architectural registers, the last
// of which reads as zero.
package hz_pkg;
    localparam int INSN_W   = 32;
    localparam int RIDX_W   = 5;
    localparam int NREG     = 1 << RIDX_W;
    localparam int OPC_W    = 6;
    localparam int FN_W     = 7;
    localparam int OPC_LO   = INSN_W - OPC_W;
    localparam int FA_LO    = 21;
    localparam int FB_LO    = 16;
    localparam int FC_LO    = 0;
    localparam int FN_LO    = 5;
    localparam int LIT_BIT  = 12;

    typedef logic [RIDX_W-1:0] ridx_t;
    localparam ridx_t ZERO_REG = ridx_t'(NREG - 1);

    localparam logic [OPC_W-1:0] OPC_ARITH = 6'h10;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'h11;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h29;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2D;
    localparam logic [OPC_W-1:0] OPC_BRU   = 6'h30;
    localparam logic [OPC_W-1:0] OPC_BRSUB = 6'h34;
    localparam logic [OPC_W-1:0] OPC_BRZ   = 6'h39;
    localparam logic [OPC_W-1:0] OPC_BRNZ  = 6'h3D;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h1A;
    localparam logic [FN_W-1:0]  FN_MOVZ   = 7'h24;
    localparam logic [FN_W-1:0]  FN_MOVNZ  = 7'h26;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } opnd_src_e;

    typedef enum logic [1:0] {
        XFER_NONE    = 2'd0,
        XFER_ZERO    = 2'd1,
        XFER_NONZERO = 2'd2,
        XFER_ALWAYS  = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        WR_NEVER      = 2'd0,
        WR_ALWAYS     = 2'd1,
        WR_IF_ZERO    = 2'd2,
        WR_IF_NONZERO = 2'd3
    } wr_e;

    // Control fields of an instruction in decode or execute
    typedef struct packed {
        logic  valid;
        ridx_t src_a;
        logic  use_a;
        ridx_t src_b;
        logic  use_b;
        ridx_t dst;
        wr_e   wr;
        logic  is_load;
        xfer_e xfer;
    } dec_t;

    // Control fields once the write decision is resolved (memory, write-back)
    typedef struct packed {
        logic  valid;
        ridx_t dst;
        logic  we;
        logic  is_load;
    } late_t;
endpackage

// File: rtl/hz_decode.sv
`timescale 1ns/1ps
// Module hz_decode
// Turns the instruction word in the fetch/decode register into operand-use,
// destination, write-kind and control-transfer fields. Purely combinational.
// Assumes an invalid slot decodes to all-zero control (a bubble).
module hz_decode
    import hz_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    logic             lit;
    ridx_t            fa, fb, fc;
    logic             unused_bits;

    assign opc = insn[OPC_LO +: OPC_W];
    assign fn  = insn[FN_LO +: FN_W];
    assign lit = insn[LIT_BIT];
    assign fa  = insn[FA_LO +: RIDX_W];
    assign fb  = insn[FB_LO +: RIDX_W];
    assign fc  = insn[FC_LO +: RIDX_W];
    assign unused_bits = ^insn[LIT_BIT+3:LIT_BIT+1];

    // Classify the opcode into reads, writes and control transfer
    always_comb begin
        dec       = '0;
        dec.src_a = fa;
        dec.src_b = fb;
        if (valid) begin
            dec.valid = 1'b1;
            case (opc)
                OPC_ARITH, OPC_LOGIC: begin
                    dec.use_a = 1'b1;
                    dec.use_b = !lit;
                    dec.dst   = fc;
                    if (opc == OPC_LOGIC && fn == FN_MOVZ)
                        dec.wr = WR_IF_ZERO;
                    else if (opc == OPC_LOGIC && fn == FN_MOVNZ)
                        dec.wr = WR_IF_NONZERO;
                    else
                        dec.wr = WR_ALWAYS;
                end
                OPC_LOAD: begin
                    dec.use_b   = 1'b1;
                    dec.dst     = fa;
                    dec.wr      = WR_ALWAYS;
                    dec.is_load = 1'b1;
                end
                OPC_STORE: begin
                    dec.use_a = 1'b1;
                    dec.use_b = 1'b1;
                end
                OPC_BRU, OPC_BRSUB: begin
                    dec.dst  = fa;
                    dec.wr   = WR_ALWAYS;
                    dec.xfer = XFER_ALWAYS;
                end
                OPC_BRZ: begin
                    dec.use_a = 1'b1;
                    dec.xfer  = XFER_ZERO;
                end
                OPC_BRNZ: begin
                    dec.use_a = 1'b1;
                    dec.xfer  = XFER_NONZERO;
                end
                OPC_JUMP: begin
                    dec.use_b = 1'b1;
                    dec.dst   = fa;
                    dec.wr    = WR_ALWAYS;
                    dec.xfer  = XFER_ALWAYS;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hz_track.sv
`timescale 1ns/1ps
// Module hz_track
// Shadow copies of the decode/execute, execute/memory and memory/write-back
// control fields. Resolves the write enable of each instruction in execute
// (conditional moves from the operand-A zero test, register 31 never).
// Assumes the datapath pipe registers advance every cycle; a stall only holds
// fetch and decode, so the decode/execute slot takes a bubble instead.
module hz_track
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  dec_t  id_dec,
    input  logic  kill_id,
    input  logic  ex_opa_zero,
    output dec_t  idex,
    output late_t exm,
    output late_t mwb
);
    logic ex_we;

    // Resolve the write decision of the instruction now in execute
    always_comb begin
        case (idex.wr)
            WR_ALWAYS:     ex_we = 1'b1;
            WR_IF_ZERO:    ex_we = ex_opa_zero;
            WR_IF_NONZERO: ex_we = !ex_opa_zero;
            default:       ex_we = 1'b0;
        endcase
        ex_we = ex_we && idex.valid && (idex.dst != ZERO_REG);
    end

    // Advance the shadow pipe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex <= '0;
            exm  <= '0;
            mwb  <= '0;
        end else begin
            idex        <= kill_id ? '0 : id_dec;
            exm.valid   <= idex.valid;
            exm.dst     <= idex.dst;
            exm.we      <= ex_we;
            exm.is_load <= idex.is_load;
            mwb         <= exm;
        end
    end

    // A move whose test fails must leave execute without a write
    p_move_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idex.valid && ((idex.wr == WR_IF_ZERO && !ex_opa_zero) ||
                        (idex.wr == WR_IF_NONZERO && ex_opa_zero))) |=> !exm.we);

    // The write reaching the register file never targets register 31
    p_no_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mwb.we |-> (mwb.dst != ZERO_REG));
endmodule

// File: rtl/hz_fwd_pick.sv
`timescale 1ns/1ps
// Module hz_fwd_pick
// Chooses the source for one operand: execute/memory result first, then
// memory/write-back result, then the register file. Register 31 and unread
// fields never match. Also used for the decode write-through with the
// execute/memory input tied empty.
module hz_fwd_pick
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      use_src,
    input  ridx_t     src,
    input  late_t     exm,
    input  late_t     mwb,
    output opnd_src_e sel
);
    logic live, hit_exm, hit_mwb;
    logic unused_mwb;

    assign live    = use_src && (src != ZERO_REG);
    assign hit_exm = live && exm.valid && exm.we && (exm.dst == src);
    assign hit_mwb = live && mwb.valid && mwb.we && (mwb.dst == src);
    assign unused_mwb = mwb.is_load;

    // Priority select, youngest writer first
    always_comb begin
        if (hit_exm)      sel = SRC_EXMEM;
        else if (hit_mwb) sel = SRC_MEMWB;
        else              sel = SRC_REGFILE;
    end

    // A load never sits in execute/memory while its consumer is in execute
    p_exm_not_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_EXMEM) |-> !exm.is_load);

    // Any bypass comes from a stage that really writes
    p_fwd_real_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_MEMWB) |-> (mwb.we && mwb.valid));
endmodule

// File: rtl/hz_hazard_detect.sv
`timescale 1ns/1ps
// Module hz_hazard_detect
// Raises stall for a load-use pair (load in execute, reader in decode) and
// flush for a control transfer that resolves taken in execute.
// Assumes the two cases never coincide: a load is never a branch.
module hz_hazard_detect
    import hz_pkg::*;
(
    input  dec_t id_dec,
    input  dec_t idex,
    input  logic ex_opa_zero,
    output logic stall,
    output logic flush
);
    logic ld_live, hit_a, hit_b;
    logic unused_fields;

    assign unused_fields = ^{id_dec.dst, id_dec.wr, id_dec.is_load, id_dec.xfer,
                             idex.src_a, idex.use_a, idex.src_b, idex.use_b, idex.wr};

    // Load-use check against each read field of the decode instruction
    always_comb begin
        ld_live = idex.valid && idex.is_load && (idex.dst != ZERO_REG);
        hit_a   = id_dec.use_a && (id_dec.src_a == idex.dst);
        hit_b   = id_dec.use_b && (id_dec.src_b == idex.dst);
        stall   = id_dec.valid && ld_live && (hit_a || hit_b);
    end

    // Taken decision of the control transfer now in execute
    always_comb begin
        case (idex.xfer)
            XFER_ALWAYS:  flush = 1'b1;
            XFER_ZERO:    flush = ex_opa_zero;
            XFER_NONZERO: flush = !ex_opa_zero;
            default:      flush = 1'b0;
        endcase
        flush = flush && idex.valid;
    end
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
// Module hazard_ctrl (top)
// Hazard and bypass control for a five-stage in-order pipeline whose register
// file is written from decode. Decodes the fetch/decode instruction, tracks
// later stages, and drives operand selects, decode write-through, register
// write control, stall, bubble and flush.
// Assumes ex_opa_zero is computed from the bypassed operand A in execute.
module hazard_ctrl
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ifid_valid,
    input  logic [INSN_W-1:0] ifid_insn,
    input  logic              ex_opa_zero,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              id_thru_a,
    output logic              id_thru_b,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic              stall,
    output logic              idex_bubble,
    output logic              flush
);
    localparam int NOPND = 2;

    dec_t  id_dec, idex;
    late_t exm, mwb;
    late_t no_stage;
    logic  [NOPND-1:0] ex_use, id_use;
    ridx_t [NOPND-1:0] ex_src, id_src;
    opnd_src_e ex_sel [NOPND];
    opnd_src_e id_sel [NOPND];
    logic  [NOPND-1:0] thru;

    assign no_stage = '0;

    hz_decode u_decode (
        .valid (ifid_valid),
        .insn  (ifid_insn),
        .dec   (id_dec)
    );

    hz_hazard_detect u_detect (
        .id_dec      (id_dec),
        .idex        (idex),
        .ex_opa_zero (ex_opa_zero),
        .stall       (stall),
        .flush       (flush)
    );

    hz_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_dec      (id_dec),
        .kill_id     (idex_bubble),
        .ex_opa_zero (ex_opa_zero),
        .idex        (idex),
        .exm         (exm),
        .mwb         (mwb)
    );

    // Bubble into decode/execute on either a held or a cancelled decode slot
    assign idex_bubble = stall || flush;

    // Gather per-operand fields so one generate loop serves both operands
    always_comb begin
        ex_use[0] = idex.use_a;   ex_src[0] = idex.src_a;
        ex_use[1] = idex.use_b;   ex_src[1] = idex.src_b;
        id_use[0] = id_dec.use_a; id_src[0] = id_dec.src_a;
        id_use[1] = id_dec.use_b; id_src[1] = id_dec.src_b;
    end

    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
        hz_fwd_pick u_ex_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .use_src (ex_use[k]),
            .src     (ex_src[k]),
            .exm     (exm),
            .mwb     (mwb),
            .sel     (ex_sel[k])
        );
        hz_fwd_pick u_id_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .use_src (id_use[k] && id_dec.valid),
            .src     (id_src[k]),
            .exm     (no_stage),
            .mwb     (mwb),
            .sel     (id_sel[k])
        );
        assign thru[k] = (id_sel[k] == SRC_MEMWB);
    end

    assign fwd_a_sel = ex_sel[0];
    assign fwd_b_sel = ex_sel[1];
    assign id_thru_a = thru[0];
    assign id_thru_b = thru[1];
    assign rf_we     = mwb.we;
    assign rf_waddr  = mwb.dst;

    // A load-use stall lasts exactly one cycle
    p_stall_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // Stall and flush never coincide
    p_stall_flush_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && flush));

    // The slot cancelled by a flush reaches execute empty
    p_flush_empties_ex_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !idex.valid);

    // Register 31 is never a bypass source for operand A
    p_no_zero_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'd0) |-> (idex.src_a != ZERO_REG));
endmodule

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ifid_valid = 1'b0;
    logic [31:0] ifid_insn = 32'h0;
    logic        ex_opa_zero = 1'b0;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        id_thru_a, id_thru_b, rf_we, stall, idex_bubble, flush;
    logic [4:0]  rf_waddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] prog [0:15];
    int plen = 0;

    always #2.5 clk = ~clk;

    hazard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ifid_valid(ifid_valid), .ifid_insn(ifid_insn),
        .ex_opa_zero(ex_opa_zero), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .id_thru_a(id_thru_a), .id_thru_b(id_thru_b), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .stall(stall), .idex_bubble(idex_bubble), .flush(flush)
    );

    // Instruction encoders (field layout from R2)
    function automatic logic [31:0] op_reg(input int a, input int b, input int c);
        return {6'h10, 5'(a), 5'(b), 3'b0, 1'b0, 7'h20, 5'(c)};
    endfunction
    function automatic logic [31:0] op_lit(input int a, input logic [7:0] l, input int c);
        return {6'h10, 5'(a), l, 1'b1, 7'h20, 5'(c)};
    endfunction
    function automatic logic [31:0] cmov(input bit nz, input int a, input int b, input int c);
        return {6'h11, 5'(a), 5'(b), 3'b0, 1'b0, (nz ? 7'h26 : 7'h24), 5'(c)};
    endfunction
    function automatic logic [31:0] mem(input logic [5:0] opc, input int a, input int b);
        return {opc, 5'(a), 5'(b), 16'h0};
    endfunction
    function automatic logic [31:0] brx(input logic [5:0] opc, input int a);
        return {opc, 5'(a), 21'h0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ifid_valid = 1'b0; ifid_insn = 32'h0; #1;
        end
    endtask

    // Feed prog[] like a fetch unit that honours stall; check consumer at cons
    task automatic run_seq(input int cons, input logic z, input string tag,
                           input int e_st, input int e_ta, input int e_tb,
                           input int e_fa, input int e_fb);
        int idx = 0;
        bit seen = 0, pend = 0;
        for (int cyc = 0; cyc < plen + 6; cyc++) begin
            @(negedge clk);
            ifid_valid  = (idx < plen);
            ifid_insn   = (idx < plen) ? prog[idx] : 32'h0;
            ex_opa_zero = z;
            #1;
            if (pend) begin
                chk({tag, " fwd_a"}, int'(fwd_a_sel), e_fa);
                chk({tag, " fwd_b"}, int'(fwd_b_sel), e_fb);
                pend = 0;
            end
            if (idx == cons && idx < plen) begin
                if (!seen) begin
                    chk({tag, " stall"}, int'(stall), e_st);
                    chk({tag, " thru_a"}, int'(id_thru_a), e_ta);
                    chk({tag, " thru_b"}, int'(id_thru_b), e_tb);
                    seen = 1;
                end
                if (!stall) pend = 1;
            end
            if (!stall && idx < plen) idx++;
        end
    endtask

    // Branch in execute: flush, link write-through, cancelled slot (R8, R11)
    task automatic run_branch(input logic [31:0] bi, input logic z, input int taken,
                              input int link, input string nm);
        @(negedge clk); ifid_valid = 1'b1; ifid_insn = bi; ex_opa_zero = z; #1;
        @(negedge clk); ifid_insn = mem(6'h29, 3, 22); #1;
        chk({"R8 flush ", nm}, int'(flush), taken);
        chk({"R8 bubble ", nm}, int'(idex_bubble), taken);
        chk({"R8 no stall ", nm}, int'(stall), 0);
        if (taken != 0) begin
            @(negedge clk); ifid_valid = 1'b0; #1;
            @(negedge clk); ifid_valid = 1'b1; ifid_insn = op_reg(3, 5, 23); #1;
            chk({"R8 link thru ", nm}, int'(id_thru_b), link);
            chk({"R8 link rf_we ", nm}, int'(rf_we), link);
            if (link != 0) chk({"R8 link addr ", nm}, int'(rf_waddr), 5);
            @(negedge clk); ifid_valid = 1'b0; #1;
            chk({"R11 cancelled load fwd_a ", nm}, int'(fwd_a_sel), 0);
        end else begin
            @(negedge clk); ifid_insn = op_reg(3, 5, 23); #1;
            chk({"R7 not-taken load survives ", nm}, int'(stall), 1);
        end
        idle(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        report();
    end

    initial begin
        // R1: reset with a load waiting in decode
        ifid_valid = 1'b1;
        ifid_insn  = mem(6'h29, 3, 22);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 stall", int'(stall), 0);
        chk("R1 flush", int'(flush), 0);
        chk("R1 bubble", int'(idex_bubble), 0);
        chk("R1 fwd_a", int'(fwd_a_sel), 0);
        chk("R1 fwd_b", int'(fwd_b_sel), 0);
        chk("R1 thru", int'(id_thru_a | id_thru_b), 0);
        chk("R1 rf_we", int'(rf_we), 0);
        idle(5);

        // Sweep: producer kind x distance x register x consumer kind
        for (int p = 0; p < 8; p++)
        for (int d = 1; d <= 3; d++)
        for (int rs = 0; rs < 2; rs++)
        for (int c = 0; c < 4; c++) begin
            int r = rs ? 31 : 3;
            logic z;
            bit pw, ow, pl, ua, ub, w1, w2, w3;
            int est, efa, efb;
            string req, tag;
            z  = (p == 3 || p == 6);
            pw = ((p <= 3) || (p == 5)) && (r != 31);
            ow = (r != 31);
            pl = (p == 2);
            prog[0] = op_reg(21, 22, r);
            case (p)
                0: prog[1] = op_reg(21, 22, r);
                1: prog[1] = op_lit(21, 8'h05, r);
                2: prog[1] = mem(6'h29, r, 22);
                3, 4: prog[1] = cmov(1'b0, 21, 22, r);
                5, 6: prog[1] = cmov(1'b1, 21, 22, r);
                default: prog[1] = mem(6'h2D, r, 22);
            endcase
            for (int f = 0; f < d - 1; f++) prog[2 + f] = op_reg(21, 22, 20);
            case (c)
                0: begin prog[d + 1] = op_reg(r, r, 23);                  ua = 1; ub = 1; end
                1: begin prog[d + 1] = op_lit(r, {5'(r), 3'b0}, 23);      ua = 1; ub = 0; end
                2: begin prog[d + 1] = mem(6'h2D, r, r);                   ua = 1; ub = 1; end
                default: begin prog[d + 1] = mem(6'h29, r, r);             ua = 0; ub = 1; end
            endcase
            for (int f = 0; f < 3; f++) prog[d + 2 + f] = op_reg(21, 22, 20);
            plen = d + 5;
            w1 = (d == 1) ? pw : 1'b0;
            w2 = (d == 2) ? pw : ((d == 1) ? ow : 1'b0);
            w3 = (d == 3) ? pw : ((d == 2) ? ow : 1'b0);
            est = (pl && w1 && (ua || ub)) ? 1 : 0;
            if (est != 0) begin
                efa = (ua && w1) ? 2 : 0;
                efb = (ub && w1) ? 2 : 0;
            end else begin
                efa = !ua ? 0 : (w1 ? 1 : (w2 ? 2 : 0));
                efb = !ub ? 0 : (w1 ? 1 : (w2 ? 2 : 0));
            end
            if (r == 31)              req = "R5";
            else if (c == 1 || c == 3) req = "R6";
            else if (p >= 3 && p <= 6) req = "R9";
            else if (p == 7)           req = "R10";
            else if (p == 2)           req = "R7";
            else                       req = "R3";
            tag = $sformatf("%s/R4 p%0d d%0d r%0d c%0d", req, p, d, r, c);
            run_seq(d + 1, z, tag, est, (ua && w3) ? 1 : 0, (ub && w3) ? 1 : 0, efa, efb);
        end

        // R8: control transfers in execute, link register 5
        run_branch(brx(6'h39, 5), 1'b1, 1, 0, "beq taken");
        run_branch(brx(6'h39, 5), 1'b0, 0, 0, "beq not taken");
        run_branch(brx(6'h3D, 5), 1'b0, 1, 0, "bne taken");
        run_branch(brx(6'h3D, 5), 1'b1, 0, 0, "bne not taken");
        run_branch(brx(6'h30, 5), 1'b0, 1, 1, "br");
        run_branch(brx(6'h34, 5), 1'b1, 1, 1, "bsr");
        run_branch(mem(6'h1A, 5, 22), 1'b0, 1, 1, "jmp");

        // R11: invalid slot shaped like a load does not stall or bypass
        @(negedge clk); ifid_valid = 1'b0; ifid_insn = mem(6'h29, 3, 22); ex_opa_zero = 1'b0; #1;
        @(negedge clk); ifid_valid = 1'b1; ifid_insn = op_reg(3, 3, 23); #1;
        chk("R11 invalid load no stall", int'(stall), 0);
        @(negedge clk); ifid_valid = 1'b0; #1;
        chk("R11 invalid load no bypass", int'(fwd_a_sel), 0);
        idle(4);

        // R2: unknown opcode (0x00) neither writes nor reads
        @(negedge clk); ifid_valid = 1'b1; ifid_insn = {6'h00, 5'd3, 5'd3, 16'h0003}; #1;
        @(negedge clk); ifid_insn = op_reg(3, 3, 23); #1;
        @(negedge clk); ifid_valid = 1'b0; #1;
        chk("R2 unknown opcode no bypass a", int'(fwd_a_sel), 0);
        chk("R2 unknown opcode no bypass b", int'(fwd_b_sel), 0);
        idle(4);

        report();
    end
endmodule